// File: doc/BRIEF.md
# Two-Lane Double-Precision Predicate Comparator

This unit compares two 128-bit operands, each carrying two IEEE-754 binary64 lanes, under a relation chosen by an 8-bit immediate. Each lane pair is compared on its own. Each 64-bit lane of the result is a mask: all ones when the relation holds, all zeros when it does not. A single flag reports whether any lane met an invalid-operation condition. Downstream logic can use a mask as a select, or combine it bitwise with data.

Operand A is always the left-hand side of the relation. Greater-than and greater-or-equal forms are not encoded. The caller gets them by swapping A and B and using one of the less-than predicates.

The result sits behind one register stage, which is controlled by a two-state machine. The state ST_EMPTY means no result was captured on the last edge. The state ST_LOADED means a result was captured on the last edge. Transition T_CAPTURE (`in_valid` high) enters ST_LOADED from either state. Transition T_DRAIN (`in_valid` low) returns to ST_EMPTY. `out_valid` is high exactly in ST_LOADED.

Top module: `pdcmp_unit`

## Requirements
- R1: The predicate code is `in_imm[2:0]`: 0 eq, 1 lt, 2 le, 3 unord, 4 neq, 5 nlt, 6 nle, 7 ord. Bits 7:3 of `in_imm` have no effect on the result or on the flag.
- R2: Lane 0 occupies bits 63:0 and lane 1 occupies bits 127:64 of the operands and of `out_result`. Each result lane is 64 ones when its relation is true and 64 zeros when it is false, and it depends only on the same lane of the operands.
- R3: A is the left operand. For example, lt is true when A < B, and a greater-than test is made by swapping the operands under lt.
- R4: A lane value is a NaN when its exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. If either value in a lane is a NaN, then eq, lt, le and ord give false, and unord, neq, nlt and nle give true.
- R5: A quiet NaN (fraction bit 51 set) in either lane operand raises invalid under lt, le, nlt and nle. It does not raise invalid under eq, unord, neq or ord.
- R6: A signaling NaN (fraction bit 51 clear) in either lane operand raises invalid under every predicate.
- R7: +0 and -0 compare as equal. Subnormal values are ordered by their exact magnitude.
- R8: Ordered values follow sign-magnitude rules. A negative value is less than a positive one, and between two negatives the larger magnitude is the smaller value.
- R9: `out_invalid` is the OR of the two lanes' invalid conditions.
- R10: When `in_valid` is high on a clock edge, the result and the flag from the inputs at that edge appear on the outputs, and `out_valid` is high for the following cycle. Without a strobe, `out_valid` is low and `out_result` and `out_invalid` hold their values.
- R11: While `rst_n` is low, `out_valid`, `out_result` and `out_invalid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the operands and immediate |
| in_a | input | 128 | Left operands, two binary64 lanes |
| in_b | input | 128 | Right operands, two binary64 lanes |
| in_imm | input | 8 | Predicate immediate; bits 2:0 are used |
| out_valid | output | 1 | High for one cycle after a capture |
| out_result | output | 128 | Two 64-bit lane masks |
| out_invalid | output | 1 | Invalid-operation flag for the captured compare |

## Verification
The assertions assume that the operands and the immediate are stable and known at the clock edge where `in_valid` is high. They also assume that `in_valid` is never X once reset is released. The bench changes every input only on the falling clock edge and holds each strobe for exactly one cycle. Its random operands come from a pool of zeros of both signs, subnormals, infinities, quiet and signaling NaNs, and arbitrary bit patterns, so every predicate meets every class of special value in both lanes.

// File: rtl/pdcmp_pkg.sv
package pdcmp_pkg;

    typedef enum logic [2:0] {
        PRED_EQ    = 3'd0,
        PRED_LT    = 3'd1,
        PRED_LE    = 3'd2,
        PRED_UNORD = 3'd3,
        PRED_NEQ   = 3'd4,
        PRED_NLT   = 3'd5,
        PRED_NLE   = 3'd6,
        PRED_ORD   = 3'd7
    } pred_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic nan;
        logic quiet;
    } fp_class_t;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } out_state_e;

endpackage

// File: rtl/pdcmp_classify.sv
module pdcmp_classify
    import pdcmp_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic [LANE_W-1:0] val,
    output fp_class_t         cls
);
    localparam int FRAC_W = LANE_W - 1 - EXP_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f     = val[LANE_W-2 -: EXP_W];
        frac_f    = val[FRAC_W-1:0];
        cls.sign  = val[LANE_W-1];
        cls.zero  = (val[LANE_W-2:0] == '0);
        cls.nan   = (&exp_f) && (frac_f != '0);
        cls.quiet = frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/pdcmp_lane.sv
module pdcmp_lane
    import pdcmp_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic [LANE_W-1:0] lhs,
    input  logic [LANE_W-1:0] rhs,
    input  pred_e             pred,
    output logic              hit,
    output logic              invalid
);
    fp_class_t cls_l, cls_r;
    logic      unord, is_eq, is_lt, is_le, mag_lt, mag_eq, any_snan, any_qnan;

    pdcmp_classify #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_cls_l (.val(lhs), .cls(cls_l));
    pdcmp_classify #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_cls_r (.val(rhs), .cls(cls_r));

    always_comb begin
        unord    = cls_l.nan | cls_r.nan;
        any_snan = (cls_l.nan & ~cls_l.quiet) | (cls_r.nan & ~cls_r.quiet);
        any_qnan = (cls_l.nan & cls_l.quiet) | (cls_r.nan & cls_r.quiet);
        mag_lt   = lhs[LANE_W-2:0] < rhs[LANE_W-2:0];
        mag_eq   = lhs[LANE_W-2:0] == rhs[LANE_W-2:0];

        is_eq = ~unord & ((cls_l.zero & cls_r.zero) | (mag_eq & (cls_l.sign == cls_r.sign)));

        if (unord || (cls_l.zero && cls_r.zero))
            is_lt = 1'b0;
        else if (cls_l.sign != cls_r.sign)
            is_lt = cls_l.sign;
        else if (cls_l.sign)
            is_lt = ~mag_lt & ~mag_eq;
        else
            is_lt = mag_lt;

        is_le = is_lt | is_eq;

        unique case (pred)
            PRED_EQ:    hit = is_eq;
            PRED_LT:    hit = is_lt;
            PRED_LE:    hit = is_le;
            PRED_UNORD: hit = unord;
            PRED_NEQ:   hit = ~is_eq;
            PRED_NLT:   hit = ~is_lt;
            PRED_NLE:   hit = ~is_le;
            PRED_ORD:   hit = ~unord;
        endcase

        unique case (pred)
            PRED_LT, PRED_LE, PRED_NLT, PRED_NLE: invalid = any_snan | any_qnan;
            default:                              invalid = any_snan;
        endcase
    end
endmodule

// File: rtl/pdcmp_unit.sv
module pdcmp_unit
    import pdcmp_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 64,
    parameter int EXP_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] in_a,
    input  logic [LANES*LANE_W-1:0] in_b,
    input  logic [7:0]              in_imm,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_result,
    output logic                    out_invalid
);
    localparam int DATA_W = LANES * LANE_W;

    pred_e                  pred;
    logic [LANES-1:0]       lane_hit, lane_inv;
    logic [DATA_W-1:0]      mask_next;
    out_state_e             state_q, state_d;
    logic                   unused_imm;

    assign pred       = pred_e'(in_imm[2:0]);
    assign unused_imm = ^in_imm[7:3];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pdcmp_lane #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_lane (
            .lhs     (in_a[g*LANE_W +: LANE_W]),
            .rhs     (in_b[g*LANE_W +: LANE_W]),
            .pred    (pred),
            .hit     (lane_hit[g]),
            .invalid (lane_inv[g])
        );
        assign mask_next[g*LANE_W +: LANE_W] = {LANE_W{lane_hit[g]}};
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else if (in_valid) begin
            out_result  <= mask_next;
            out_invalid <= |lane_inv;
        end
    end

    assign out_valid = (state_q == ST_LOADED);
endmodule

// File: rtl/pdcmp_unit_chk.sv
module pdcmp_unit_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 64,
    parameter int EXP_W  = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [LANES*LANE_W-1:0] in_a,
    input logic [LANES*LANE_W-1:0] in_b,
    input logic [7:0]              in_imm,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] out_result,
    input logic                    out_invalid
);
    localparam int FRAC_W = LANE_W - 1 - EXP_W;

    function automatic logic is_snan(input logic [LANE_W-1:0] v);
        return (&v[LANE_W-2:FRAC_W]) && (v[FRAC_W-2:0] != '0) && !v[FRAC_W-1];
    endfunction

    function automatic logic is_nan(input logic [LANE_W-1:0] v);
        return (&v[LANE_W-2:FRAC_W]) && (v[FRAC_W-1:0] != '0);
    endfunction

    logic snan_seen;
    always_comb begin
        snan_seen = 1'b0;
        for (int i = 0; i < LANES; i++)
            snan_seen |= is_snan(in_a[i*LANE_W +: LANE_W]) | is_snan(in_b[i*LANE_W +: LANE_W]);
    end

    a_r10_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_no_strobe_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result) && $stable(out_invalid));
    a_r6_snan_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && snan_seen) |=> out_invalid);
    a_r4_nan_eq_false: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_imm[2:0] == 3'd0 && is_nan(in_a[LANE_W-1:0]))
            |=> out_result[LANE_W-1:0] == '0);
    a_r4_nan_unord_true: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_imm[2:0] == 3'd3 && is_nan(in_b[LANE_W-1:0]))
            |=> &out_result[LANE_W-1:0]);

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        a_r2_full_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (&out_result[g*LANE_W +: LANE_W]) || (out_result[g*LANE_W +: LANE_W] == '0));
    end
endmodule

bind pdcmp_unit pdcmp_unit_chk #(.LANES(LANES), .LANE_W(LANE_W), .EXP_W(EXP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_imm(in_imm), .out_valid(out_valid), .out_result(out_result),
    .out_invalid(out_invalid)
);

// File: tb/tb_pdcmp_unit.sv
module tb_pdcmp_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_a = '0, in_b = '0;
    logic [7:0]   in_imm = '0;
    logic         out_valid, out_invalid;
    logic [127:0] out_result;
    int           n_checks = 0, n_errors = 0;

    always #2.5 clk = ~clk;

    pdcmp_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_imm(in_imm), .out_valid(out_valid), .out_result(out_result),
        .out_invalid(out_invalid)
    );

    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] SUB1   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] SUB2   = 64'h0000_0000_0000_0002;

    function automatic logic isnan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    // returns {invalid, hit}
    function automatic logic [1:0] ref_lane(input logic [63:0] a, input logic [63:0] b,
                                            input logic [2:0] p);
        logic un, eq, lt, hit, qn, sn;
        real  ra, rb;
        un = isnan(a) || isnan(b);
        qn = (isnan(a) && a[51]) || (isnan(b) && b[51]);
        sn = (isnan(a) && !a[51]) || (isnan(b) && !b[51]);
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        eq = !un && (ra == rb);
        lt = !un && (ra < rb);
        case (p)
            3'd0: hit = eq;
            3'd1: hit = lt;
            3'd2: hit = lt || eq;
            3'd3: hit = un;
            3'd4: hit = !eq;
            3'd5: hit = !lt;
            3'd6: hit = !(lt || eq);
            default: hit = !un;
        endcase
        return {sn || (qn && (p == 3'd1 || p == 3'd2 || p == 3'd5 || p == 3'd6)), hit};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [63:0] a1, input logic [63:0] a0,
                          input logic [63:0] b1, input logic [63:0] b0, input logic [7:0] imm);
        logic [1:0] r0, r1;
        r0 = ref_lane(a0, b0, imm[2:0]);
        r1 = ref_lane(a1, b1, imm[2:0]);
        @(negedge clk);
        in_a = {a1, a0}; in_b = {b1, b0}; in_imm = imm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {127'd0, out_valid}, 128'd1);
        check({tag, " result"}, out_result, {{64{r1[0]}}, {64{r0[0]}}});
        check({tag, " invalid"}, {127'd0, out_invalid}, {127'd0, r1[1] | r0[1]});
    endtask

    function automatic logic [63:0] pick(input int k);
        case (k)
            0: return P_ZERO;  1: return N_ZERO;  2: return P_ONE;  3: return N_ONE;
            4: return N_TWO;   5: return P_INF;   6: return N_INF;  7: return QNAN;
            8: return SNAN;    9: return SUB1;   10: return SUB2;
            11: return {1'b1, 11'h7FF, 1'b1, 51'($urandom)};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R11 reset valid", {127'd0, out_valid}, 128'd0);
        check("R11 reset result", out_result, 128'd0);
        check("R11 reset invalid", {127'd0, out_invalid}, 128'd0);
        rst_n = 1'b1;

        run_op("R7 signed zero eq", P_ZERO, N_ZERO, N_ZERO, P_ZERO, 8'h00);
        run_op("R7 subnormal lt", SUB2, SUB1, SUB1, SUB2, 8'h01);
        run_op("R8 negative lt", N_ONE, N_TWO, N_TWO, N_ONE, 8'h01);
        run_op("R8 sign order le", P_ONE, N_ONE, N_ONE, P_ONE, 8'h02);
        run_op("R3 swap for gt", P_ONE, N_ONE, N_ONE, P_ONE, 8'h01);
        run_op("R1 reserved bits", N_ONE, P_ONE, P_ONE, N_ONE, 8'hF9);
        run_op("R1 reserved bit3", N_ONE, P_ONE, P_ONE, N_ONE, 8'h09);
        run_op("R2 lane independence", QNAN, P_ONE, P_ONE, P_ONE, 8'h03);
        run_op("R4 nan ord false", P_ONE, QNAN, P_ONE, P_ONE, 8'h07);
        run_op("R4 nan nle true", P_ONE, P_ONE, QNAN, QNAN, 8'h06);
        run_op("R5 qnan eq quiet", P_ONE, QNAN, P_ONE, P_ONE, 8'h00);
        run_op("R5 qnan neq quiet", P_ONE, QNAN, P_ONE, P_ONE, 8'h04);
        run_op("R5 qnan lt raises", P_ONE, QNAN, P_ONE, P_ONE, 8'h01);
        run_op("R5 qnan nlt raises", P_ONE, P_ONE, P_ONE, QNAN, 8'h05);
        run_op("R6 snan eq raises", P_ONE, SNAN, P_ONE, P_ONE, 8'h00);
        run_op("R6 snan unord raises", P_ONE, P_ONE, P_ONE, SNAN, 8'h03);
        run_op("R9 lane1 invalid only", SNAN, P_ONE, P_ONE, P_ONE, 8'h07);
        run_op("R4 inf eq", P_INF, N_INF, P_INF, N_INF, 8'h00);

        held = out_result;
        @(negedge clk);
        check("R10 idle valid low", {127'd0, out_valid}, 128'd0);
        check("R10 idle result held", out_result, held);

        for (int i = 0; i < 300; i++) begin
            run_op("R2 random", pick($urandom_range(0, 13)), pick($urandom_range(0, 13)),
                   pick($urandom_range(0, 13)), pick($urandom_range(0, 13)),
                   8'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule